// File: doc/BRIEF.md
# Configurable GPIO port controller

This block is one port of general-purpose pins, eight wide by default. Software reaches three registers through a small register bus: an output latch, a per-pin direction mask and a per-pin option mask. Together, each pin's direction bit and option bit pick one of four behaviours. A pin can be a floating input, an input with a pull-up and edge interrupt, an open-drain output or a push-pull output. The block drives the pad controls (output value, output enable, pull-up enable, interrupt enable) and takes the pad levels back through a two-flop synchronizer.

The data address reads back per bit. A bit set as an output returns its latch, and a bit set as an input returns its synchronized pad level. A falling edge on any pin set as an interrupt input sets one sticky pending flag for the port. Software clears the flag with a dedicated strobe. Two parameters give build variants. One variant never drives a pin high. The other variant drops the option register.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset, all three registers hold 0, every pin is a floating input (pad_oe, pad_pu and pad_ie all 0, pad_out 0) and irq is 0.
- R2: Address 0 selects the data latch, 1 the direction mask and 2 the option mask. A write with bus_wr high takes effect at the next rising clock edge. bus_rdata follows bus_addr combinationally, and address 3 reads 0.
- R3: A write to the data latch is kept while the pin is an input, and it appears on the pad once the pin becomes a push-pull output.
- R4: A data read returns, per bit, the latch when the direction bit is 1, or the pad level delayed by two clock edges when the direction bit is 0.
- R5: An input pin with option 0 is floating: pad_oe, pad_pu and pad_ie are 0.
- R6: An input pin with option 1 has pad_pu and pad_ie at 1 and pad_oe at 0.
- R7: An output pin with option 1 is push-pull: pad_oe is 1 and pad_out equals the latch bit.
- R8: An output pin with option 0 is open-drain: pad_out is 0 and pad_oe is the inverse of the latch bit.
- R9: With PP_RESERVED=1, every output pin behaves as open-drain whatever its option bit holds, so no pin is ever driven high.
- R10: With HAS_OPTION=0, the option address reads 0 and writes to it are ignored. Input pins are floating, and output pins are push-pull.
- R11: A 1-to-0 change of a pad set as an interrupt input sets irq at the third rising edge after the change. Rising edges and edges on other pins leave irq unchanged. irq stays set until cleared.
- R12: A high irq_clear at a rising edge clears irq, unless a qualifying falling edge is being detected in that same cycle, in which case irq stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Combinational read data |
| irq_clear | input | 1 | Clear strobe for the pending flag |
| pad_in | input | W | Pad levels, asynchronous |
| pad_out | output | W | Pad output value |
| pad_oe | output | W | Pad output enable |
| pad_pu | output | W | Pad pull-up enable |
| pad_ie | output | W | Pad interrupt enable |
| irq | output | 1 | Sticky interrupt request |

## Verification
The pending flag can receive a clear strobe and a new detected falling edge in the same cycle. The bench first sets the flag. It then drops the interrupt pin again and raises irq_clear exactly on the edge where the synchronized level first shows the drop, two edges after the pad change. irq must still read 1 afterwards, and a later clear on its own must bring irq to 0.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_OPT  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PM_FLOAT,
        PM_IRQ_IN,
        PM_OPEN_DRAIN,
        PM_PUSH_PULL
    } pin_mode_e;

    typedef struct packed {
        logic out;
        logic oe;
        logic pu;
        logic ie;
    } pad_ctrl_t;

    // Direction picks input/output; the option bit picks the sub-mode.
    function automatic pin_mode_e decode_mode(input logic dir, input logic opt,
                                              input logic pp_reserved);
        if (!dir)
            return opt ? PM_IRQ_IN : PM_FLOAT;
        else if (opt && !pp_reserved)
            return PM_PUSH_PULL;
        else
            return PM_OPEN_DRAIN;
    endfunction

    function automatic pad_ctrl_t mode_to_pad(input pin_mode_e m, input logic latch);
        pad_ctrl_t c;
        c = '0;
        case (m)
            PM_IRQ_IN:     begin c.pu = 1'b1; c.ie = 1'b1; end
            PM_OPEN_DRAIN: begin c.oe = ~latch; end
            PM_PUSH_PULL:  begin c.oe = 1'b1; c.out = latch; end
            default:       c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W          = 8,
    parameter bit HAS_OPTION = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] opt_q
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (wr) begin
            if (sel == REG_DATA) data_q <= wdata;
            if (sel == REG_DIR)  dir_q  <= wdata;
        end
    end

    generate
        if (HAS_OPTION) begin : g_opt
            always_ff @(posedge clk) begin
                if (rst)                        opt_q <= '0;
                else if (wr && sel == REG_OPT)  opt_q <= wdata;
            end
        end else begin : g_no_opt
            assign opt_q = '0;
        end
    endgenerate

    AST_DATA_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == REG_DATA) |=> (data_q == $past(wdata))); // R3
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr && sel == REG_DIR) |=> $stable(dir_q)); // R2
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         st[s] <= '0;
                else if (s == 0) st[s] <= d;
                else             st[s] <= st[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_port_pinctl.sv
module gpio_port_pinctl
    import gpio_port_pkg::*;
#(
    parameter int W           = 8,
    parameter bit PP_RESERVED = 1'b0
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] opt,
    input  logic [W-1:0] latch,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu,
    output logic [W-1:0] pad_ie
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            pin_mode_e mode;
            pad_ctrl_t ctl;
            assign mode       = decode_mode(dir[i], opt[i], PP_RESERVED);
            assign ctl        = mode_to_pad(mode, latch[i]);
            assign pad_out[i] = ctl.out;
            assign pad_oe[i]  = ctl.oe;
            assign pad_pu[i]  = ctl.pu;
            assign pad_ie[i]  = ctl.ie;
        end
    endgenerate
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] ie,
    input  logic         clr,
    output logic         pend
);
    logic [W-1:0] prev_q;
    logic         hit;

    assign hit = |(prev_q & ~lvl & ie);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend   <= 1'b0;
        end else begin
            prev_q <= lvl;
            pend   <= (pend & ~clr) | hit;
        end
    end

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend); // R11
    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|($past(lvl) & ~lvl & ie)) |=> pend); // R12
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W           = 8,
    parameter bit HAS_OPTION  = 1'b1,
    parameter bit PP_RESERVED = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         irq_clear,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu,
    output logic [W-1:0] pad_ie,
    output logic         irq
);
    logic [W-1:0] data_q, dir_q, opt_q, opt_eff, lvl;

    gpio_port_regs #(.W(W), .HAS_OPTION(HAS_OPTION)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .data_q(data_q), .dir_q(dir_q), .opt_q(opt_q)
    );

    gpio_port_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(lvl)
    );

    // Without an option register, direction alone decides: floating in, push-pull out.
    assign opt_eff = HAS_OPTION ? opt_q : dir_q;

    gpio_port_pinctl #(.W(W), .PP_RESERVED(PP_RESERVED)) u_pins (
        .dir(dir_q), .opt(opt_eff), .latch(data_q),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_ie(pad_ie)
    );

    gpio_port_irq #(.W(W)) u_irq (
        .clk(clk), .rst(rst), .lvl(lvl), .ie(pad_ie), .clr(irq_clear), .pend(irq)
    );

    always_comb begin
        case (reg_sel_e'(bus_addr))
            REG_DATA: bus_rdata = (data_q & dir_q) | (lvl & ~dir_q);
            REG_DIR:  bus_rdata = dir_q;
            REG_OPT:  bus_rdata = opt_q;
            default:  bus_rdata = '0;
        endcase
    end

    AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & ~dir_q) == '0)); // R5
    AST_PULLUP_INPUT_ONLY: assert property (@(posedge clk) disable iff (rst)
        ((pad_pu & dir_q) == '0)); // R6

    generate
        if (PP_RESERVED) begin : g_rsv_chk
            AST_RSV_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
                ((pad_oe & pad_out) == '0)); // R9
        end
    endgenerate
endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   bus_addr = 2'd0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic         irq_clear = 1'b0;
    logic [W-1:0] pad_in = '0;

    logic [W-1:0] rd_a, out_a, oe_a, pu_a, ie_a;
    logic [W-1:0] rd_b, out_b, oe_b, pu_b, ie_b;
    logic [W-1:0] rd_c, out_c, oe_c, pu_c, ie_c;
    logic         irq_a, irq_b, irq_c;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_port #(.W(W)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(rd_a), .irq_clear(irq_clear), .pad_in(pad_in),
        .pad_out(out_a), .pad_oe(oe_a), .pad_pu(pu_a), .pad_ie(ie_a), .irq(irq_a));

    gpio_port #(.W(W), .PP_RESERVED(1'b1)) uut_od (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(rd_b), .irq_clear(irq_clear), .pad_in(pad_in),
        .pad_out(out_b), .pad_oe(oe_b), .pad_pu(pu_b), .pad_ie(ie_b), .irq(irq_b));

    gpio_port #(.W(W), .HAS_OPTION(1'b0)) uut_nopt (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(rd_c), .irq_clear(irq_clear), .pad_in(pad_in),
        .pad_out(out_c), .pad_oe(oe_c), .pad_pu(pu_c), .pad_ie(ie_c), .irq(irq_c));

    // {dir, opt, data, exp_out, exp_oe, exp_pu, exp_ie}
    localparam logic [55:0] VEC [6] = '{
        {8'hFF, 8'hFF, 8'hA5, 8'hA5, 8'hFF, 8'h00, 8'h00},
        {8'hFF, 8'h00, 8'hA5, 8'h00, 8'h5A, 8'h00, 8'h00},
        {8'h00, 8'h00, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00},
        {8'h00, 8'hFF, 8'h3C, 8'h00, 8'h00, 8'hFF, 8'hFF},
        {8'hF0, 8'hCC, 8'h96, 8'h80, 8'hE0, 8'h0C, 8'h0C},
        {8'h0F, 8'h5A, 8'hFF, 8'h0A, 8'h0A, 8'h50, 8'h50}
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_sel(input logic [1:0] a);
        bus_addr = a;
        #1;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);

        // R1 reset state
        chk("R1 oe", oe_a, 8'h00);
        chk("R1 pu", pu_a, 8'h00);
        chk("R1 ie", ie_a, 8'h00);
        chk("R1 out", out_a, 8'h00);
        chk("R1 irq", {7'd0, irq_a}, 8'h00);
        rd_sel(2'd1); chk("R1 dir read", rd_a, 8'h00);
        rd_sel(2'd2); chk("R1 opt read", rd_a, 8'h00);

        // Vector walk: R5 R6 R7 R8, plus R9 and R10 variants and R4 read-back
        pad_in = 8'h33;
        for (int v = 0; v < 6; v++) begin
            logic [W-1:0] dv, ov, lv;
            {dv, ov, lv} = VEC[v][55:32];
            wr(2'd0, lv); wr(2'd1, dv); wr(2'd2, ov);
            chk("R5/R6/R7/R8 out", out_a, VEC[v][31:24]);
            chk("R5/R6/R7/R8 oe",  oe_a,  VEC[v][23:16]);
            chk("R5/R6/R7/R8 pu",  pu_a,  VEC[v][15:8]);
            chk("R5/R6/R7/R8 ie",  ie_a,  VEC[v][7:0]);
            chk("R9 out", out_b, 8'h00);
            chk("R9 oe", oe_b, dv & ~lv);
            chk("R10 oe", oe_c, dv);
            chk("R10 out", out_c, dv & lv);
            chk("R10 pu", pu_c, 8'h00);
            rd_sel(2'd0); chk("R4 data read", rd_a, (lv & dv) | (8'h33 & ~dv));
            rd_sel(2'd2); chk("R2 opt read", rd_a, ov);
            chk("R10 opt read", rd_c, 8'h00);
            rd_sel(2'd1); chk("R2 dir read", rd_a, dv);
        end
        rd_sel(2'd3); chk("R2 unused address", rd_a, 8'h00);

        // R3 latch written while input
        wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'hC3);
        rd_sel(2'd0); chk("R3 input reads pad", rd_a, 8'h33);
        chk("R3 no drive as input", oe_a, 8'h00);
        wr(2'd2, 8'hFF); wr(2'd1, 8'hFF);
        chk("R3 latch on pad", out_a, 8'hC3);
        rd_sel(2'd0); chk("R3 latch read", rd_a, 8'hC3);

        // R4 synchronizer depth
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        pad_in = 8'hFF; cyc(3);
        pad_in = 8'h5A;
        rd_sel(2'd0); chk("R4 before first edge", rd_a, 8'hFF);
        cyc(1); chk("R4 one edge", rd_a, 8'hFF);
        cyc(1); chk("R4 two edges", rd_a, 8'h5A);

        // R11 interrupt detection
        irq_clear = 1'b1; cyc(1); irq_clear = 1'b0;
        wr(2'd2, 8'h01);
        pad_in = 8'h00; cyc(4);
        irq_clear = 1'b1; cyc(1); irq_clear = 1'b0;
        pad_in = 8'hFF; cyc(4);
        chk("R11 rising edge ignored", {7'd0, irq_a}, 8'h00);
        pad_in = 8'hFE; cyc(2);
        chk("R11 not yet after two edges", {7'd0, irq_a}, 8'h00);
        cyc(1);
        chk("R11 set on third edge", {7'd0, irq_a}, 8'h01);
        pad_in = 8'hFF; cyc(4);
        chk("R11 sticky", {7'd0, irq_a}, 8'h01);

        // R12 clear alone
        irq_clear = 1'b1; cyc(1); irq_clear = 1'b0;
        chk("R12 clear", {7'd0, irq_a}, 8'h00);
        pad_in = 8'hFD; cyc(4);
        chk("R11 floating pin fall ignored", {7'd0, irq_a}, 8'h00);

        // R12 clear and new edge in the same cycle
        pad_in = 8'hFF; cyc(4);
        pad_in = 8'hFE; cyc(4);
        pad_in = 8'hFF; cyc(4);
        chk("R12 pre-set", {7'd0, irq_a}, 8'h01);
        pad_in = 8'hFE; cyc(2);
        irq_clear = 1'b1; cyc(1); irq_clear = 1'b0;
        chk("R12 edge wins over clear", {7'd0, irq_a}, 8'h01);
        cyc(2);
        irq_clear = 1'b1; cyc(1); irq_clear = 1'b0;
        chk("R12 later clear", {7'd0, irq_a}, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule